// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer with Annul Control

This block holds the program counter state for an in-order RISC front end whose branches are delayed. Two addresses are kept. The execute address belongs to the instruction now executing. The fetch address names the instruction that follows it. Because of this split, the instruction placed after a branch, called the delay slot, has already entered the pipe when the branch resolves, so a taken branch costs no bubble.

Each cycle the execute stage presents a short control record for the instruction at the execute address. The record says whether the instruction is a branch, whether its condition holds, whether its annul bit is set, and what its target is. From this record the block computes both addresses for the next cycle and a one-cycle kill flag. The kill flag travels with the delay-slot instruction and makes it behave as a no-op, blocking its register writeback and its condition-code update. The kill is raised only when a branch with the annul bit set is not taken. If a delay-slot instruction has been killed, its own control record is disregarded, so a killed branch cannot steer fetch.

Top module: `dslot_fetch_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, `exec_pc` takes RESET_VEC, `fetch_addr` takes RESET_VEC + WORD_BYTES (4 by default) and `slot_kill` clears, all visible after that edge.
- R2: A live instruction that is not a branch (`ex_branch`=0) moves `exec_pc` to the old `fetch_addr` and `fetch_addr` to the old `fetch_addr` + 4 at the next edge.
- R3: A live taken branch (`ex_branch`=1, `ex_cond_met`=1) moves `exec_pc` to the old `fetch_addr`, which is the delay slot, and `fetch_addr` to the target at the next edge. No bubble is inserted.
- R4: A live branch that is not taken and has `ex_annul`=0 advances sequentially as in R2 and leaves `slot_kill` low, so the delay slot executes.
- R5: A live branch that is not taken and has `ex_annul`=1 advances sequentially and raises `slot_kill` for exactly the following cycle, which is the cycle in which the delay slot sits at `exec_pc`.
- R6: A live taken branch with `ex_annul`=1 redirects as in R3 and leaves `slot_kill` low.
- R7: While `slot_kill` is high, the control record is ignored. `fetch_addr` advances by 4 whatever the branch, condition, annul and target inputs are, and `slot_kill` is low on the next cycle.
- R8: Bits [1:0] of `ex_target` are ignored. A redirected `fetch_addr` always has bits [1:0] equal to zero, and so does every `exec_pc`.
- R9: `slot_kill` is never high except in the cycle directly after a live, not-taken branch with `ex_annul`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ex_branch | input | 1 | Instruction at `exec_pc` is a branch |
| ex_cond_met | input | 1 | Condition of that branch holds |
| ex_annul | input | 1 | Annul bit of that branch |
| ex_target | input | ADDR_W | Branch target address, low bits ignored |
| exec_pc | output | ADDR_W | Address of the instruction executing this cycle |
| fetch_addr | output | ADDR_W | Address of the instruction that follows it |
| slot_kill | output | 1 | Instruction at `exec_pc` is annulled this cycle |

## Verification
Every result is registered once. A control record sampled at edge N therefore shows its effect on `exec_pc`, `fetch_addr` and `slot_kill` right after edge N, and a kill lands on the delay slot one cycle after the branch that caused it. The bench drives each record on a falling edge. On the next falling edge it compares the outputs with its behavioural model, and only then drives the following record, so each comparison falls exactly one register stage after the stimulus it belongs to. It also collects the addresses that retire, meaning those not killed, and compares that sequence with the model's sequence after a directed trace and a random run.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

   // How the address pair moves on the coming edge
   typedef enum logic [1:0] {
      STEP_SEQ      = 2'd0,   // delay slot next, then fall through
      STEP_REDIRECT = 2'd1,   // delay slot next, then the branch target
      STEP_SQUASHED = 2'd2    // current slot is dead: record ignored
   } step_e;

   typedef struct packed {
      step_e kind;
      logic  arm_kill;        // kill the instruction that follows
   } step_t;

endpackage

// File: rtl/dsf_resolve.sv
module dsf_resolve
   import dsf_pkg::*;
(
   input  logic  is_branch,
   input  logic  cond_met,
   input  logic  annul,
   input  logic  slot_dead,
   output step_t step
);

   logic live_br;

   assign live_br = is_branch & ~slot_dead;

   always_comb begin
      step.arm_kill = 1'b0;
      if (slot_dead) begin
         step.kind = STEP_SQUASHED;
      end else if (live_br && cond_met) begin
         step.kind = STEP_REDIRECT;
      end else begin
         step.kind = STEP_SEQ;
         step.arm_kill = live_br & annul;
      end
   end

endmodule

// File: rtl/dsf_align.sv
module dsf_align #(
   parameter int ADDR_W   = 32,
   parameter int LOW_BITS = 2
) (
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out
);

   generate
      if (LOW_BITS == 0) begin : g_pass
         assign addr_out = addr_in;
      end else begin : g_mask
         assign addr_out = {addr_in[ADDR_W-1:LOW_BITS], {LOW_BITS{1'b0}}};
      end
   endgenerate

endmodule

// File: rtl/dsf_pc_pair.sv
module dsf_pc_pair
   import dsf_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] RESET_VEC = '0,
   parameter int                STEP_B    = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  step_e             kind,
   input  logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] cur_q,
   output logic [ADDR_W-1:0] nxt_q
);

   localparam logic [ADDR_W-1:0] INC = ADDR_W'(STEP_B);

   logic [ADDR_W-1:0] nxt_d;

   always_comb begin
      unique case (kind)
         STEP_REDIRECT: nxt_d = target;
         default:       nxt_d = nxt_q + INC;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cur_q <= RESET_VEC;
         nxt_q <= RESET_VEC + INC;
      end else begin
         cur_q <= nxt_q;
         nxt_q <= nxt_d;
      end
   end

endmodule

// File: rtl/dsf_kill_flag.sv
module dsf_kill_flag (
   input  logic clk,
   input  logic rst,
   input  logic arm,
   output logic kill_q
);

   always_ff @(posedge clk) begin
      if (rst) kill_q <= 1'b0;
      else     kill_q <= arm;
   end

endmodule

// File: rtl/dslot_fetch_seq.sv
module dslot_fetch_seq
   import dsf_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter int                WORD_BYTES = 4,
   parameter logic [ADDR_W-1:0] RESET_VEC  = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ex_branch,
   input  logic              ex_cond_met,
   input  logic              ex_annul,
   input  logic [ADDR_W-1:0] ex_target,
   output logic [ADDR_W-1:0] exec_pc,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic              slot_kill
);

   localparam int ALIGN_BITS = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 0;

   generate
      if (WORD_BYTES < 1 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
         $error("WORD_BYTES must be a power of two");
      end
      if (ADDR_W <= ALIGN_BITS + 1) begin : g_bad_width
         $error("ADDR_W too narrow for the word size");
      end
      if (ALIGN_BITS > 0) begin : g_vec_chk
         if (RESET_VEC[ALIGN_BITS-1:0] != '0) begin : g_bad_vec
            $error("RESET_VEC must be word aligned");
         end
      end
   endgenerate

   step_t             step;
   logic [ADDR_W-1:0] tgt_aligned;

   dsf_resolve u_resolve (
      .is_branch (ex_branch),
      .cond_met  (ex_cond_met),
      .annul     (ex_annul),
      .slot_dead (slot_kill),
      .step      (step)
   );

   dsf_align #(.ADDR_W(ADDR_W), .LOW_BITS(ALIGN_BITS)) u_align (
      .addr_in  (ex_target),
      .addr_out (tgt_aligned)
   );

   dsf_pc_pair #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC), .STEP_B(WORD_BYTES)) u_pcs (
      .clk    (clk),
      .rst    (rst),
      .kind   (step.kind),
      .target (tgt_aligned),
      .cur_q  (exec_pc),
      .nxt_q  (fetch_addr)
   );

   dsf_kill_flag u_kill (
      .clk    (clk),
      .rst    (rst),
      .arm    (step.arm_kill),
      .kill_q (slot_kill)
   );

endmodule

// File: rtl/dslot_fetch_seq_chk.sv
module dslot_fetch_seq_chk #(
   parameter int                ADDR_W     = 32,
   parameter int                WORD_BYTES = 4,
   parameter logic [ADDR_W-1:0] RESET_VEC  = '0
) (
   input logic              clk,
   input logic              rst,
   input logic              ex_branch,
   input logic              ex_cond_met,
   input logic              ex_annul,
   input logic [ADDR_W-1:0] ex_target,
   input logic [ADDR_W-1:0] exec_pc,
   input logic [ADDR_W-1:0] fetch_addr,
   input logic              slot_kill
);

   localparam logic [ADDR_W-1:0] INC = ADDR_W'(WORD_BYTES);
   localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(WORD_BYTES - 1);

   // R1
   a_r1_reset_state: assert property (@(posedge clk)
      rst |=> (exec_pc == RESET_VEC && fetch_addr == RESET_VEC + INC && !slot_kill));

   // R2, R4, R7: sequential advance
   a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
      (!ex_branch || !ex_cond_met || slot_kill) |=>
         (exec_pc == $past(fetch_addr) && fetch_addr == $past(fetch_addr) + INC));

   // R3, R6, R8: redirect to the aligned target after the delay slot
   a_r3_redirect: assert property (@(posedge clk) disable iff (rst)
      (ex_branch && ex_cond_met && !slot_kill) |=>
         (exec_pc == $past(fetch_addr) && fetch_addr == ($past(ex_target) & ~LOW_MASK)));

   // R5
   a_r5_kill_slot: assert property (@(posedge clk) disable iff (rst)
      (ex_branch && !ex_cond_met && ex_annul && !slot_kill) |=> slot_kill);

   // R7: a killed slot never kills its successor
   a_r7_single_kill: assert property (@(posedge clk) disable iff (rst)
      slot_kill |=> !slot_kill);

   // R9
   a_r9_no_spurious_kill: assert property (@(posedge clk) disable iff (rst)
      (!ex_branch || ex_cond_met || !ex_annul) |=> !slot_kill);

   // R8
   a_r8_aligned: assert property (@(posedge clk) disable iff (rst)
      ((exec_pc & LOW_MASK) == '0) && ((fetch_addr & LOW_MASK) == '0));

endmodule

bind dslot_fetch_seq dslot_fetch_seq_chk #(
   .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .RESET_VEC(RESET_VEC)
) u_chk (
   .clk(clk), .rst(rst), .ex_branch(ex_branch), .ex_cond_met(ex_cond_met),
   .ex_annul(ex_annul), .ex_target(ex_target), .exec_pc(exec_pc),
   .fetch_addr(fetch_addr), .slot_kill(slot_kill)
);

// File: tb/dslot_fetch_seq_bench.sv
`timescale 1ns/1ps
module dslot_fetch_seq_bench;

   localparam logic [31:0] RV = 32'h0000_1000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        br = 1'b0, cnd = 1'b0, ann = 1'b0;
   logic [31:0] tgt = '0;
   logic [31:0] exec_pc, fetch_addr;
   logic        slot_kill;

   int compared = 0;
   int mismatched = 0;

   // behavioural reference
   logic [31:0] m_pc, m_npc;
   logic        m_kill;
   string       tag_pc, tag_k;
   logic [31:0] dut_ret[$];
   logic [31:0] ref_ret[$];

   always #2 clk = ~clk;

   dslot_fetch_seq #(.ADDR_W(32), .WORD_BYTES(4), .RESET_VEC(RV)) u_dslot_fetch_seq (
      .clk(clk), .rst(rst), .ex_branch(br), .ex_cond_met(cnd), .ex_annul(ann),
      .ex_target(tgt), .exec_pc(exec_pc), .fetch_addr(fetch_addr), .slot_kill(slot_kill)
   );

   task automatic check_now();
      compared++;
      if (exec_pc !== m_pc || fetch_addr !== m_npc) begin
         mismatched++;
         $display("FAIL %s: pc/npc got %h/%h expected %h/%h", tag_pc, exec_pc, fetch_addr, m_pc, m_npc);
      end
      compared++;
      if (slot_kill !== m_kill) begin
         mismatched++;
         $display("FAIL %s: slot_kill got %b expected %b", tag_k, slot_kill, m_kill);
      end
      if (!rst) begin
         if (!slot_kill) dut_ret.push_back(exec_pc);
         if (!m_kill)    ref_ret.push_back(m_pc);
      end
   endtask

   // compare state from the previous record, then apply a new one
   task automatic step(input logic r, input logic b, input logic c, input logic a,
                       input logic [31:0] t);
      logic [31:0] nxt;
      @(negedge clk);
      check_now();
      rst = r; br = b; cnd = c; ann = a; tgt = t;
      if (r) begin
         m_pc = RV; m_npc = RV + 4; m_kill = 1'b0;
         tag_pc = "R1"; tag_k = "R1";
      end else if (m_kill) begin
         m_pc = m_npc; m_npc = m_npc + 4; m_kill = 1'b0;
         tag_pc = "R7"; tag_k = "R7";
      end else begin
         nxt = m_npc;
         if (b && c) begin
            m_npc = {t[31:2], 2'b00};
            tag_pc = (t[1:0] != 2'b00) ? "R8" : (a ? "R6" : "R3");
            tag_k  = a ? "R6" : "R9";
         end else begin
            m_npc = m_npc + 4;
            tag_pc = b ? (a ? "R5" : "R4") : "R2";
            tag_k  = (b && a) ? "R5" : (b ? "R4" : "R9");
         end
         m_pc = nxt;
         m_kill = b && !c && a;
      end
   endtask

   initial begin
      #400000;
      mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      m_pc = 'x; m_npc = 'x; m_kill = 1'bx;
      @(negedge clk);
      rst = 1'b1;
      m_pc = RV; m_npc = RV + 4; m_kill = 1'b0; tag_pc = "R1"; tag_k = "R1";
      @(posedge clk);
      // directed trace; each record applies to the instruction now at exec_pc
      step(0, 0, 0, 0, 32'h0);           // 1000 plain (R2)
      step(0, 1, 1, 0, 32'h0000_2003);   // 1004 taken, odd target (R8, R3)
      step(0, 0, 0, 0, 32'h0);           // 1008 delay slot runs
      step(0, 1, 0, 1, 32'h0000_3000);   // 2000 not taken, annul (R5)
      step(0, 1, 1, 1, 32'h0000_4000);   // 2004 killed branch, ignored (R7)
      step(0, 1, 1, 1, 32'h0000_5000);   // 2008 taken, annul (R6)
      step(0, 0, 0, 0, 32'h0);           // 200C slot executes
      step(0, 1, 0, 0, 32'h0000_6000);   // 5000 not taken, no annul (R4)
      step(0, 1, 1, 0, 32'h0000_7000);   // 5004 taken: slot follows
      step(0, 1, 1, 0, 32'h0000_8000);   // 5008 branch in delay slot redirects
      step(0, 0, 0, 0, 32'h0);
      step(1, 1, 0, 1, 32'h0);           // reset mid-run (R1)
      step(0, 1, 0, 1, 32'h0);
      step(0, 1, 0, 1, 32'h0);           // killed slot even though annulling
      // random phase
      for (int i = 0; i < 600; i++) begin
         step(($urandom % 97) == 0, $urandom % 2 == 0, $urandom % 2 == 0,
              $urandom % 2 == 0, $urandom);
      end
      step(0, 0, 0, 0, 32'h0);
      @(negedge clk);
      check_now();
      // retired-address stream
      compared++;
      if (dut_ret.size() != ref_ret.size()) begin
         mismatched++;
         $display("FAIL R9: retired count got %0d expected %0d", dut_ret.size(), ref_ret.size());
      end else begin
         for (int i = 0; i < dut_ret.size(); i++) begin
            if (dut_ret[i] !== ref_ret[i]) begin
               mismatched++;
               $display("FAIL R5: retired[%0d] got %h expected %h", i, dut_ret[i], ref_ret[i]);
               break;
            end
         end
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule